// File: doc/BRIEF.md
# Clock Control and Interrupt Unit

This block is the system-control register bank of a small microcontroller. It holds two clock configuration words. The primary word carries a 4-bit divider field, a crystal selection field and a PLL power-down flag. The secondary word carries a wider 6-bit divider field, its own PLL power-down flag, and an override bit that makes it the source of the divider. From whichever word is selected, the block derives a system clock period value equal to five times (divider + 1).

The block also keeps a 7-bit raw interrupt status with a mask and a masked view. A status bit is cleared by writing 1 to it through the masked view. Powering up the PLL (a write that clears a power-down flag that was set) sets the PLL-lock status bit. One interrupt line follows the masked status. Three further registers hold brown-out, LDO and reset-cause values, each truncated to its width on write. A read-only PLL configuration word comes from one of two 16-entry tables, chosen by a device-class strap and indexed by the crystal field. The older device class has no secondary clock word: writes to it are dropped and it reads as zero.

Software reaches the block through a plain single-cycle register port. Every write is accepted in the cycle it is presented, so the port has no back-pressure. Read data is a combinational function of the address.

Top module: `clk_ctl_unit`

## Requirements
- R1: After reset:
  - the primary clock word equals parameter CFG_A_RST;
  - the secondary clock word is 0x07802810 when class_new_i is 1 and 0 when it is 0;
  - raw status, mask, brown-out, LDO and reset-cause registers are 0;
  - irq_o is 0.
- R2: A write to the primary word (offset 0x060) or an accepted write to the secondary word (offset 0x070) that takes bit 13 from 1 to 0 sets raw status bit 6. A 0 to 0 or 0 to 1 write of bit 13 does not set it.
- R3: period_o is 5 * (field + 1), where the field depends on bit 31 of the secondary word:
  - bit 31 = 1: the field is secondary[28:23];
  - bit 31 = 0: the field is primary[26:23].
  period_o shows the new value from the clock edge that captures the write.
- R4: While class_new_i is 0, writes to offset 0x070 change nothing: the word keeps its value and no lock status is raised.
- R5: A read of offset 0x064 returns, zero-extended, the 16-bit entry at index primary[9:6] of parameter PLL_TBL_NEW when class_new_i is 1, or of PLL_TBL_OLD when it is 0. Entry i sits at bits [16*i+15:16*i], and a zero entry reads as 0.
- R6: Interrupt registers:
  - the mask (offset 0x054) keeps wdata[6:0];
  - offset 0x050 reads the raw status, and writes to it are ignored;
  - offset 0x058 reads raw AND mask;
  - a write to 0x058 clears every raw bit written as 1, whether or not that bit is masked.
- R7: irq_o is 1 exactly when raw AND mask is nonzero.
- R8: Write truncation: offset 0x030 keeps wdata[15:0], offset 0x034 keeps wdata[4:0], and offset 0x05C keeps wdata[5:0]. Each reads back zero-extended.
- R9: Reads of unmapped offsets return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| class_new_i | input | 1 | Device-class strap: 1 selects the newer class |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 12 | Byte offset for reads and writes |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| period_o | output | 9 | System clock period value, 5*(divider+1) |
| irq_o | output | 1 | Interrupt, high while masked status is nonzero |

## Verification
All register writes, the lock-status update and the status clear land on the rising edge that sees wr_en_i. Because of that, period_o, irq_o and every register read show the new value one edge after the write is presented, while rdata_o itself follows addr_i with no clock. The bench drives each write half a cycle before its capturing edge, then at the following falling edge changes the address and samples rdata_o, period_o and irq_o. Every result is therefore read exactly one edge after its cause and never at an edge. The vector walk covers truncation, mask, unmapped and lookup reads. Directed steps cover reset values, both divider sources and their limits, the lock-edge cases, clear-through-mask and the older class.

// File: rtl/clk_ctl_pkg.sv
package clk_ctl_pkg;
  localparam int ADDR_W     = 12;
  localparam int DATA_W     = 32;
  localparam int STAT_W     = 7;
  localparam int LOCK_BIT   = 6;
  localparam int PDN_BIT    = 13;
  localparam int OVR_BIT    = 31;
  localparam int DIVA_LSB   = 23;
  localparam int DIVA_W     = 4;
  localparam int DIVB_LSB   = 23;
  localparam int DIVB_W     = 6;
  localparam int XTAL_LSB   = 6;
  localparam int XTAL_W     = 4;
  localparam int PLL_N      = 1 << XTAL_W;
  localparam int PLL_EW     = 16;
  localparam int PERIOD_MUL = 5;
  localparam int PERIOD_W   = $clog2(PERIOD_MUL * (1 << DIVB_W) + 1);
  localparam int BOR_W      = 16;
  localparam int LDO_W      = 5;
  localparam int RSC_W      = 6;

  localparam logic [ADDR_W-1:0] OFS_BOR  = 12'h030;
  localparam logic [ADDR_W-1:0] OFS_LDO  = 12'h034;
  localparam logic [ADDR_W-1:0] OFS_RAW  = 12'h050;
  localparam logic [ADDR_W-1:0] OFS_MSK  = 12'h054;
  localparam logic [ADDR_W-1:0] OFS_MIS  = 12'h058;
  localparam logic [ADDR_W-1:0] OFS_RSC  = 12'h05C;
  localparam logic [ADDR_W-1:0] OFS_CFGA = 12'h060;
  localparam logic [ADDR_W-1:0] OFS_PLL  = 12'h064;
  localparam logic [ADDR_W-1:0] OFS_CFGB = 12'h070;

  localparam logic [DATA_W-1:0] CFG_B_RST_NEW = 32'h0780_2810;

  function automatic logic [PLL_N*PLL_EW-1:0] build_table(
      input logic [PLL_EW-1:0] base, input logic [PLL_EW-1:0] step);
    logic [PLL_N*PLL_EW-1:0] t;
    t = '0;
    for (int i = 0; i < PLL_N; i++) begin
      t[i*PLL_EW +: PLL_EW] = base + PLL_EW'(i) * step;
    end
    return t;
  endfunction
endpackage

// File: rtl/clk_ctl_cfg.sv
module clk_ctl_cfg
  import clk_ctl_pkg::*;
#(
  parameter logic [DATA_W-1:0] CFG_A_RST = 32'h0780_2000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                class_new_i,
  input  logic                we_a_i,
  input  logic                we_b_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   cfg_a_o,
  output logic [DATA_W-1:0]   cfg_b_o,
  output logic                lock_evt_o,
  output logic [PERIOD_W-1:0] period_o
);
  logic [DATA_W-1:0] cfg_a_q, cfg_b_q;
  logic              we_b_ok;
  logic [DIVB_W-1:0] div_sel;

  assign we_b_ok = we_b_i & class_new_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_a_q <= CFG_A_RST;
      cfg_b_q <= class_new_i ? CFG_B_RST_NEW : '0;
    end else begin
      if (we_a_i)  cfg_a_q <= wdata_i;
      if (we_b_ok) cfg_b_q <= wdata_i;
    end
  end

  // Power-up of the PLL: power-down flag falls on an accepted write.
  assign lock_evt_o = (we_a_i  & cfg_a_q[PDN_BIT] & ~wdata_i[PDN_BIT]) |
                      (we_b_ok & cfg_b_q[PDN_BIT] & ~wdata_i[PDN_BIT]);

  always_comb begin
    if (cfg_b_q[OVR_BIT]) div_sel = cfg_b_q[DIVB_LSB +: DIVB_W];
    else                  div_sel = DIVB_W'(cfg_a_q[DIVA_LSB +: DIVA_W]);
  end

  assign period_o = PERIOD_W'(PERIOD_MUL) * (PERIOD_W'(div_sel) + PERIOD_W'(1));
  assign cfg_a_o  = cfg_a_q;
  assign cfg_b_o  = cfg_b_q;

  // R4: older class drops secondary-word writes
  a_r4_old_class_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (we_b_i && !class_new_i) |=> $stable(cfg_b_q));

  // R3: primary field drives period when override is clear
  a_r3_primary_period: assert property (@(posedge clk) disable iff (!rst_n)
    (we_a_i && !we_b_i && !cfg_b_q[OVR_BIT]) |=>
      (int'(period_o) == PERIOD_MUL * (int'($past(wdata_i[DIVA_LSB +: DIVA_W])) + 1)));
endmodule

// File: rtl/clk_ctl_irq.sv
module clk_ctl_irq
  import clk_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock_evt_i,
  input  logic              we_mask_i,
  input  logic              we_clr_i,
  input  logic [STAT_W-1:0] wbits_i,
  output logic [STAT_W-1:0] raw_o,
  output logic [STAT_W-1:0] mask_o,
  output logic              irq_o
);
  logic [STAT_W-1:0] raw_q, mask_q, clr_bits, set_bits;

  assign clr_bits = we_clr_i ? wbits_i : '0;
  assign set_bits = lock_evt_i ? STAT_W'(1 << LOCK_BIT) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_q  <= '0;
      mask_q <= '0;
    end else begin
      raw_q <= (raw_q & ~clr_bits) | set_bits;
      if (we_mask_i) mask_q <= wbits_i;
    end
  end

  assign raw_o  = raw_q;
  assign mask_o = mask_q;
  assign irq_o  = |(raw_q & mask_q);

  // R2: lock event lands in the raw status
  a_r2_lock_sets_raw: assert property (@(posedge clk) disable iff (!rst_n)
    lock_evt_i |=> raw_q[LOCK_BIT]);

  // R6: write-one-to-clear removes every written bit
  a_r6_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (we_clr_i && !lock_evt_i) |=> ((raw_q & $past(wbits_i)) == '0));

  // R6: mask keeps the written bits
  a_r6_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    we_mask_i |=> (mask_q == $past(wbits_i)));
endmodule

// File: rtl/clk_ctl_pll_lut.sv
module clk_ctl_pll_lut
  import clk_ctl_pkg::*;
#(
  parameter logic [PLL_N*PLL_EW-1:0] TBL_NEW = '0,
  parameter logic [PLL_N*PLL_EW-1:0] TBL_OLD = '0
) (
  input  logic              class_new_i,
  input  logic [XTAL_W-1:0] xtal_i,
  output logic [PLL_EW-1:0] value_o
);
  logic [PLL_EW-1:0] ent_new [PLL_N];
  logic [PLL_EW-1:0] ent_old [PLL_N];

  for (genvar g = 0; g < PLL_N; g++) begin : g_unpack
    assign ent_new[g] = TBL_NEW[g*PLL_EW +: PLL_EW];
    assign ent_old[g] = TBL_OLD[g*PLL_EW +: PLL_EW];
  end

  assign value_o = class_new_i ? ent_new[xtal_i] : ent_old[xtal_i];
endmodule

// File: rtl/clk_ctl_unit.sv
module clk_ctl_unit
  import clk_ctl_pkg::*;
#(
  parameter logic [DATA_W-1:0]       CFG_A_RST   = 32'h0780_2000,
  parameter logic [PLL_N*PLL_EW-1:0] PLL_TBL_NEW = build_table(16'h3000, 16'h0107),
  parameter logic [PLL_N*PLL_EW-1:0] PLL_TBL_OLD = build_table(16'h1800, 16'h00C3)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                class_new_i,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic [PERIOD_W-1:0] period_o,
  output logic                irq_o
);
  logic [DATA_W-1:0] cfg_a, cfg_b;
  logic [STAT_W-1:0] raw, mask;
  logic [PLL_EW-1:0] pll_val;
  logic              lock_evt;
  logic [BOR_W-1:0]  bor_q;
  logic [LDO_W-1:0]  ldo_q;
  logic [RSC_W-1:0]  rsc_q;

  logic we_a, we_b, we_msk, we_mis, we_bor, we_ldo, we_rsc;
  assign we_a   = wr_en_i && (addr_i == OFS_CFGA);
  assign we_b   = wr_en_i && (addr_i == OFS_CFGB);
  assign we_msk = wr_en_i && (addr_i == OFS_MSK);
  assign we_mis = wr_en_i && (addr_i == OFS_MIS);
  assign we_bor = wr_en_i && (addr_i == OFS_BOR);
  assign we_ldo = wr_en_i && (addr_i == OFS_LDO);
  assign we_rsc = wr_en_i && (addr_i == OFS_RSC);

  clk_ctl_cfg #(.CFG_A_RST(CFG_A_RST)) u_cfg (
    .clk(clk), .rst_n(rst_n), .class_new_i(class_new_i),
    .we_a_i(we_a), .we_b_i(we_b), .wdata_i(wdata_i),
    .cfg_a_o(cfg_a), .cfg_b_o(cfg_b), .lock_evt_o(lock_evt),
    .period_o(period_o)
  );

  clk_ctl_irq u_irq (
    .clk(clk), .rst_n(rst_n), .lock_evt_i(lock_evt),
    .we_mask_i(we_msk), .we_clr_i(we_mis), .wbits_i(wdata_i[STAT_W-1:0]),
    .raw_o(raw), .mask_o(mask), .irq_o(irq_o)
  );

  clk_ctl_pll_lut #(.TBL_NEW(PLL_TBL_NEW), .TBL_OLD(PLL_TBL_OLD)) u_lut (
    .class_new_i(class_new_i), .xtal_i(cfg_a[XTAL_LSB +: XTAL_W]),
    .value_o(pll_val)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bor_q <= '0;
      ldo_q <= '0;
      rsc_q <= '0;
    end else begin
      if (we_bor) bor_q <= wdata_i[BOR_W-1:0];
      if (we_ldo) ldo_q <= wdata_i[LDO_W-1:0];
      if (we_rsc) rsc_q <= wdata_i[RSC_W-1:0];
    end
  end

  always_comb begin
    unique case (addr_i)
      OFS_BOR:  rdata_o = DATA_W'(bor_q);
      OFS_LDO:  rdata_o = DATA_W'(ldo_q);
      OFS_RAW:  rdata_o = DATA_W'(raw);
      OFS_MSK:  rdata_o = DATA_W'(mask);
      OFS_MIS:  rdata_o = DATA_W'(raw & mask);
      OFS_RSC:  rdata_o = DATA_W'(rsc_q);
      OFS_CFGA: rdata_o = cfg_a;
      OFS_PLL:  rdata_o = DATA_W'(pll_val);
      OFS_CFGB: rdata_o = cfg_b;
      default:  rdata_o = '0;
    endcase
  end

  // R8: reset-cause register keeps only its low bits
  a_r8_rsc_trunc: assert property (@(posedge clk) disable iff (!rst_n)
    we_rsc |=> (rsc_q == $past(wdata_i[RSC_W-1:0])));

  // R7: interrupt line agrees with masked view
  a_r7_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i == OFS_MIS) |-> (irq_o == (rdata_o != '0)));
endmodule

// File: tb/tb_clk_ctl_unit.sv
module tb_clk_ctl_unit;
  localparam int CLK_PERIOD = 10;

  function automatic logic [255:0] tb_tbl(input logic [15:0] base,
                                          input logic [15:0] step,
                                          input int hole);
    logic [255:0] t;
    t = '0;
    for (int i = 0; i < 16; i++)
      t[i*16 +: 16] = (i == hole) ? 16'h0 : base + 16'(i) * step;
    return t;
  endfunction

  function automatic logic [31:0] tb_ent(input logic [255:0] t, input int idx);
    return {16'h0, t[idx*16 +: 16]};
  endfunction

  localparam logic [31:0]  RST_A   = 32'h0780_2000;
  localparam logic [255:0] TBL_NEW = tb_tbl(16'h4000, 16'h0123, 5);
  localparam logic [255:0] TBL_OLD = tb_tbl(16'h8000, 16'h0051, 9);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        class_new = 1'b1;
  logic        wr_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [8:0]  period;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clk_ctl_unit #(.CFG_A_RST(RST_A), .PLL_TBL_NEW(TBL_NEW), .PLL_TBL_OLD(TBL_OLD)) dut (
    .clk(clk), .rst_n(rst_n), .class_new_i(class_new), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .period_o(period), .irq_o(irq)
  );

  typedef struct packed {
    logic [23:0] tag;
    logic [11:0] wa;
    logic [31:0] wd;
    logic [11:0] ra;
    logic [31:0] ex;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{"R8 ", 12'h030, 32'hFFFF_ABCD, 12'h030, 32'h0000_ABCD},
    '{"R8 ", 12'h034, 32'hFFFF_FFFF, 12'h034, 32'h0000_001F},
    '{"R8 ", 12'h05C, 32'hFFFF_FFC5, 12'h05C, 32'h0000_0005},
    '{"R6 ", 12'h054, 32'hFFFF_FFF3, 12'h054, 32'h0000_0073},
    '{"R6 ", 12'h050, 32'h0000_007F, 12'h050, 32'h0000_0000},
    '{"R9 ", 12'h200, 32'hFFFF_FFFF, 12'h200, 32'h0000_0000},
    '{"R5 ", 12'h060, 32'h0000_20C0, 12'h064, tb_ent(TBL_NEW, 3)},
    '{"R5 ", 12'h060, 32'h0000_2140, 12'h064, 32'h0000_0000},
    '{"R5 ", 12'h060, 32'h0000_23C0, 12'h064, tb_ent(TBL_NEW, 15)}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // called at a falling edge; the write is captured at the next rising edge
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    addr = a;
    #1;
    chk(tag, rdata, exp);
  endtask

  task automatic do_reset(input logic cls);
    class_new = cls;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    do_reset(1'b1);
    // R1 reset state, newer class
    rd_chk("R1 primary reset", 12'h060, RST_A);
    rd_chk("R1 secondary reset", 12'h070, 32'h0780_2810);
    rd_chk("R1 raw reset", 12'h050, 32'h0);
    rd_chk("R1 reset-cause reset", 12'h05C, 32'h0);
    chk("R1 R3 reset period", 32'(period), 32'd80);
    chk("R1 irq reset", 32'(irq), 32'd0);

    for (int i = 0; i < 9; i++) begin
      @(negedge clk);
      wr(VECS[i].wa, VECS[i].wd);
      rd_chk({string'(VECS[i].tag), "vector"}, VECS[i].ra, VECS[i].ex);
    end

    // R3 primary source, field 2
    @(negedge clk);
    wr(12'h060, 32'h0100_2000);
    chk("R3 primary field 2", 32'(period), 32'd15);
    rd_chk("R2 no lock when flag stays set", 12'h050, 32'h0);
    // R3 override, field 42
    wr(12'h070, 32'h9500_2000);
    chk("R3 secondary field 42", 32'(period), 32'd215);
    rd_chk("R3 secondary readback", 12'h070, 32'h9500_2000);
    // R3 max field
    wr(12'h070, 32'h9F80_2000);
    chk("R3 secondary field 63", 32'(period), 32'd320);
    // R3 override off
    wr(12'h070, 32'h1F80_2000);
    chk("R3 back to primary", 32'(period), 32'd15);

    // R2 falling flag on primary word, mask 0x73 holds bit 6
    wr(12'h060, 32'h0100_0000);
    rd_chk("R2 lock from primary", 12'h050, 32'h40);
    chk("R7 irq raised", 32'(irq), 32'd1);
    rd_chk("R6 masked view", 12'h058, 32'h40);
    // R6 clear
    @(negedge clk);
    wr(12'h058, 32'h0000_0040);
    rd_chk("R6 cleared", 12'h050, 32'h0);
    chk("R7 irq dropped", 32'(irq), 32'd0);
    // R2 0 to 0 and 0 to 1
    wr(12'h060, 32'h0100_0000);
    rd_chk("R2 no lock 0 to 0", 12'h050, 32'h0);
    @(negedge clk);
    wr(12'h060, 32'h0100_2000);
    rd_chk("R2 no lock 0 to 1", 12'h050, 32'h0);
    // R2 falling flag on secondary word
    @(negedge clk);
    wr(12'h070, 32'h1F80_0000);
    rd_chk("R2 lock from secondary", 12'h050, 32'h40);
    // R7 masked off
    @(negedge clk);
    wr(12'h054, 32'h0000_003F);
    chk("R7 irq masked", 32'(irq), 32'd0);
    rd_chk("R6 masked view empty", 12'h058, 32'h0);
    @(negedge clk);
    wr(12'h058, 32'h0000_0040);
    rd_chk("R6 clear through mask", 12'h050, 32'h0);

    // older class
    @(negedge clk);
    do_reset(1'b0);
    rd_chk("R1 secondary reset old class", 12'h070, 32'h0);
    rd_chk("R5 old table index 0", 12'h064, tb_ent(TBL_OLD, 0));
    @(negedge clk);
    wr(12'h054, 32'h0000_007F);
    wr(12'h070, 32'h9500_2000);
    rd_chk("R4 write dropped", 12'h070, 32'h0);
    chk("R4 period unchanged", 32'(period), 32'd80);
    @(negedge clk);
    wr(12'h060, 32'h0780_2240);
    rd_chk("R5 old table zero entry", 12'h064, 32'h0);
    @(negedge clk);
    wr(12'h060, 32'h0780_2080);
    rd_chk("R5 old table index 2", 12'h064, tb_ent(TBL_OLD, 2));
    rd_chk("R4 no lock in old class", 12'h050, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule